// File: doc/BRIEF.md
# Serial Controller Register Pointer Front End

This block is the bus-facing register access stage of a two-channel serial controller whose internal registers are reached indirectly. Software first writes a register index into control register 0 of a channel. The next control access on that channel then reads or writes the chosen register. After that access the index falls back to zero, so the following control access again reaches register 0. Accesses made with the data/control select line set to data go to a per-channel data byte and leave the index alone.

The bus is asynchronous and has an active-low strobe. A single bus cycle spans several controller clocks, so the strobe is synchronized and every side effect is applied once, at the strobe's release. The active index copies the pending value only while the synchronized strobe is released. The register seen by a read therefore cannot change while the read is still in progress. The block also keeps one external/status interrupt-pending flag per channel. It returns an interrupt vector through channel B's register 2 and clears a channel's flag when that channel receives a reset command byte. The event inputs are synchronous to the controller clock.

Top module: `sio_regptr`

## Requirements
- R1: After reset both pending flags are 0, `bus_rdata` is 0 and both register indices are 0, so the first control read on either channel returns register 0.
- R2: A control write to a channel while its index is 0 stores `bus_wdata[3:0]` as the next index. The following control access on that channel, started after the strobe has been released for at least 5 clocks, reaches that register (index 1 included).
- R3: After a control access to any register other than 0, the channel's index returns to 0. A control read reaches register 0 again, and it returns the channel's pending flag in bit 0 with all other bits 0.
- R4: The active index does not change while the synchronized strobe is asserted, so `bus_rdata` holds one value from the first clock after the strobe falls until the strobe rises.
- R5: Reading register 2 of channel B returns `{4'b0, vs, 1'b0}`. `vs` is 3'b101 when channel A's flag is set, 3'b001 when only channel B's flag is set and 3'b011 when neither is set, so the byte is 0x0A, 0x02 or 0x06.
- R6: A high `ext_evt[c]` sets the pending flag `ext_pend[c]` (bit 0 is channel A, bit 1 is channel B), and the flag stays set after the event input falls.
- R7: A control write of 0x10 while the index is 0 (bits 5:3 equal to 3'b010) clears that channel's pending flag only and leaves the index at 0.
- R8: When a channel's event input is high in the cycle its clear command takes effect, the flag stays set.
- R9: Registers 1 to 15 hold the bytes written to them, separately for each channel, and read back unchanged. The exception is channel B register 2, which returns the vector.
- R10: A data access (`bus_data_sel`=1) reads or writes the channel's data byte and leaves its register index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_as_n | input | 1 | Bus strobe, active low, asynchronous |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_chan_b | input | 1 | 1 = channel B, 0 = channel A |
| bus_data_sel | input | 1 | 1 = data byte, 0 = control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the strobe is low, 0 otherwise |
| ext_evt | input | 2 | External/status event per channel |
| ext_pend | output | 2 | External/status pending flag per channel |

## Verification
The clear command and a new external/status event can reach the same channel's pending flag in the same cycle. The bench provokes this by holding that channel's event input high across the whole bus cycle that carries the 0x10 command. It judges the result at the ports: the flag must still read 1 after the command and after the event falls, and a later command with no event must clear it. The pointer's deferred update is judged by sampling the read data on every clock of a 4-clock strobe.

// File: rtl/sio_regptr_pkg.sv
package sio_regptr_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_CH   = 2;
    localparam int NUM_REGS = 16;
    localparam int PTR_W    = $clog2(NUM_REGS);

    localparam int CH_A = 0;
    localparam int CH_B = 1;

    // command field of a control byte written at index 0
    localparam int          CMD_LSB     = 3;
    localparam logic [2:0]  CMD_CLR_EXT = 3'b010;

    // register index that carries the vector on channel B
    localparam logic [PTR_W-1:0] VEC_IDX = PTR_W'(2);

    typedef struct packed {
        logic              rd;
        logic              ch;
        logic              data_sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [2:0] {
        VS_A_PEND = 3'b101,
        VS_B_PEND = 3'b001,
        VS_NONE   = 3'b011
    } vec_stat_e;

    function automatic vec_stat_e vec_status(input logic pend_a, input logic pend_b);
        if (pend_a)      return VS_A_PEND;
        else if (pend_b) return VS_B_PEND;
        else             return VS_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] vec_byte(input vec_stat_e vs);
        logic [DATA_W-1:0] b;
        b = '0;
        b[3:1] = vs;
        return b;
    endfunction

endpackage

// File: rtl/sio_strobe_sync.sv
module sio_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n_async,
    output logic strobe_n_sync
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= strobe_n_async;
            end
            assign strobe_n_sync = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], strobe_n_async};
            end
            assign strobe_n_sync = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sio_chan.sv
module sio_chan
    import sio_regptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,      // synchronized strobe released
    input  logic              fire,      // bus cycle for this channel ends
    input  bus_req_t          req,
    input  logic              evt,
    output logic [PTR_W-1:0]  ptr,
    output logic              pend,
    output logic [DATA_W-1:0] cur_reg,
    output logic [DATA_W-1:0] data_byte
);
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  latch_q;
    logic              pend_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    logic ctrl_fire;
    logic at_zero;
    logic clr_cmd;

    assign ctrl_fire = fire && !req.data_sel;
    assign at_zero   = (ptr_q == '0);
    assign clr_cmd   = ctrl_fire && at_zero && !req.rd &&
                       (req.wdata[CMD_LSB +: 3] == CMD_CLR_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            latch_q <= '0;
        end else begin
            if (idle)
                ptr_q <= latch_q;
            if (ctrl_fire) begin
                if (at_zero) begin
                    if (!req.rd)
                        latch_q <= req.wdata[PTR_W-1:0];
                end else begin
                    latch_q <= '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (evt)     pend_q <= 1'b1;
        else if (clr_cmd) pend_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            for (int i = 0; i < NUM_REGS; i++)
                regs_q[i] <= '0;
        end else begin
            if (fire && req.data_sel && !req.rd)
                data_q <= req.wdata;
            if (ctrl_fire && !at_zero && !req.rd)
                regs_q[ptr_q] <= req.wdata;
        end
    end

    assign ptr       = ptr_q;
    assign pend      = pend_q;
    assign cur_reg   = regs_q[ptr_q];
    assign data_byte = data_q;
endmodule

// File: rtl/sio_regptr.sv
module sio_regptr
    import sio_regptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_as_n,
    input  logic              bus_rd,
    input  logic              bus_chan_b,
    input  logic              bus_data_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ext_evt,
    output logic [NUM_CH-1:0] ext_pend
);
    logic              as_s;
    logic              as_prev_q;
    logic              fire;
    bus_req_t          cap_q;
    logic [PTR_W-1:0]  ptr_q     [NUM_CH];
    logic [DATA_W-1:0] cur_reg   [NUM_CH];
    logic [DATA_W-1:0] data_byte [NUM_CH];
    logic [NUM_CH-1:0] pend;
    vec_stat_e         vec_stat;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    sio_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk            (clk),
        .rst            (rst),
        .strobe_n_async (bus_as_n),
        .strobe_n_sync  (as_s)
    );

    // bus fields captured while the raw strobe is low
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q     <= '0;
            as_prev_q <= 1'b1;
        end else begin
            as_prev_q <= as_s;
            if (!bus_as_n)
                cap_q <= '{rd: bus_rd, ch: bus_chan_b,
                           data_sel: bus_data_sel, wdata: bus_wdata};
        end
    end

    assign fire = as_s && !as_prev_q;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            sio_chan u_chan (
                .clk       (clk),
                .rst       (rst),
                .idle      (as_s),
                .fire      (fire && (int'(cap_q.ch) == c)),
                .req       (cap_q),
                .evt       (ext_evt[c]),
                .ptr       (ptr_q[c]),
                .pend      (pend[c]),
                .cur_reg   (cur_reg[c]),
                .data_byte (data_byte[c])
            );
        end
    endgenerate

    assign vec_stat = vec_status(pend[CH_A], pend[CH_B]);

    always_comb begin
        if (bus_data_sel)
            rd_mux = data_byte[bus_chan_b];
        else if (ptr_q[bus_chan_b] == '0)
            rd_mux = {{(DATA_W-1){1'b0}}, pend[bus_chan_b]};
        else if (bus_chan_b && ptr_q[bus_chan_b] == VEC_IDX)
            rd_mux = vec_byte(vec_stat);
        else
            rd_mux = cur_reg[bus_chan_b];
    end

    always_ff @(posedge clk) begin
        if (rst || bus_as_n) rdata_q <= '0;
        else                 rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign ext_pend  = pend;
endmodule

// File: rtl/sio_regptr_chk.sv
module sio_regptr_chk
    import sio_regptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_s,
    input  logic              fire,
    input  logic              cap_rd,
    input  logic              cap_ch,
    input  logic              cap_data_sel,
    input  logic [DATA_W-1:0] cap_wdata,
    input  logic [PTR_W-1:0]  ptr_a,
    input  logic [PTR_W-1:0]  ptr_b,
    input  logic [NUM_CH-1:0] ext_evt,
    input  logic [NUM_CH-1:0] ext_pend,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [2:0]        vec_stat
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0)
            reset_state_chk: assert (ext_pend == '0 && bus_rdata == '0 &&
                                     ptr_a == '0 && ptr_b == '0);
    end

    // R4
    ptr_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !as_s |=> $stable(ptr_a));

    // R4
    ptr_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !as_s |=> $stable(ptr_b));

    // R5
    vec_a_prio_chk: assert property (@(posedge clk) disable iff (rst)
        ext_pend[0] |-> (vec_stat == 3'b101));

    // R5
    vec_none_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_pend == 2'b00) |-> (vec_stat == 3'b011));

    // R7
    clr_a_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !cap_ch && !cap_rd && !cap_data_sel && ptr_a == '0 &&
         cap_wdata == 8'h10 && !ext_evt[0]) |=> !ext_pend[0]);

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ext_evt[0] |=> ext_pend[0]);

    // R8
    evt_wins_b_chk: assert property (@(posedge clk) disable iff (rst)
        ext_evt[1] |=> ext_pend[1]);
endmodule

bind sio_regptr sio_regptr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .as_s         (as_s),
    .fire         (fire),
    .cap_rd       (cap_q.rd),
    .cap_ch       (cap_q.ch),
    .cap_data_sel (cap_q.data_sel),
    .cap_wdata    (cap_q.wdata),
    .ptr_a        (ptr_q[0]),
    .ptr_b        (ptr_q[1]),
    .ext_evt      (ext_evt),
    .ext_pend     (ext_pend),
    .bus_rdata    (bus_rdata),
    .vec_stat     (vec_stat)
);

// File: tb/sio_regptr_bench.sv
module sio_regptr_bench;
    localparam int HOLD = 4;
    localparam int GAP  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_as_n = 1'b1;
    logic       bus_rd = 1'b1;
    logic       bus_chan_b = 1'b0;
    logic       bus_data_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] ext_evt = 2'b00;
    logic [1:0] ext_pend;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] exp_reg [2][16];

    always #5 clk = ~clk;

    sio_regptr u_sio_regptr (
        .clk          (clk),
        .rst          (rst),
        .bus_as_n     (bus_as_n),
        .bus_rd       (bus_rd),
        .bus_chan_b   (bus_chan_b),
        .bus_data_sel (bus_data_sel),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ext_evt      (ext_evt),
        .ext_pend     (ext_pend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] vec_exp(input logic pa, input logic pb);
        int vs;
        vs = pa ? 5 : (pb ? 1 : 3);
        return 8'(vs * 2);
    endfunction

    task automatic bus(input logic rd, input logic ch, input logic dsel,
                       input logic [7:0] wd, output logic [7:0] rdv);
        @(negedge clk);
        bus_rd = rd; bus_chan_b = ch; bus_data_sel = dsel; bus_wdata = wd;
        bus_as_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        rdv = bus_rdata;
        bus_as_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic ctrl_wr(input logic ch, input logic [7:0] v);
        logic [7:0] d;
        bus(1'b0, ch, 1'b0, v, d);
    endtask

    task automatic ctrl_rd(input logic ch, output logic [7:0] v);
        bus(1'b1, ch, 1'b0, 8'h00, v);
    endtask

    task automatic pulse_evt(input logic [1:0] m);
        @(negedge clk); ext_evt = m;
        @(negedge clk); ext_evt = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 pend", {6'b0, ext_pend}, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        ctrl_rd(1'b0, r); chk("R1 first read A", r, 8'h00);
        ctrl_rd(1'b1, r); chk("R1 first read B", r, 8'h00);

        // R5/R6: sweep of pending combinations
        for (int m = 0; m < 4; m++) begin
            pulse_evt(2'(m));
            chk("R6 pend set", {6'b0, ext_pend}, 8'(m));
            ctrl_rd(1'b0, r); chk("R6 RR0 A bit0", r, 8'(m & 1));
            ctrl_rd(1'b1, r); chk("R6 RR0 B bit0", r, 8'((m >> 1) & 1));
            ctrl_wr(1'b1, 8'h02);
            ctrl_rd(1'b1, r);
            chk("R5 vector", r, vec_exp(m[0], m[1]));
            ctrl_wr(1'b0, 8'h10);
            ctrl_wr(1'b1, 8'h10);
            chk("R7 both cleared", {6'b0, ext_pend}, 8'h00);
        end

        // R2/R9: write every register of both channels
        for (int c = 0; c < 2; c++)
            for (int n = 1; n < 16; n++) begin
                exp_reg[c][n] = 8'(c * 64 + n * 7 + 3);
                ctrl_wr(1'(c), 8'(n));
                ctrl_wr(1'(c), exp_reg[c][n]);
            end
        for (int c = 0; c < 2; c++)
            for (int n = 1; n < 16; n++) begin
                ctrl_wr(1'(c), 8'(n));
                ctrl_rd(1'(c), r);
                if (c == 1 && n == 2) chk("R5 vector idle", r, 8'h06);
                else                  chk("R9 readback", r, exp_reg[c][n]);
                ctrl_rd(1'(c), r);
                chk("R3 back to reg0", r, 8'h00);
            end

        // R2: index 1 set then written back to back
        ctrl_wr(1'b0, 8'h01); ctrl_wr(1'b0, 8'hC3); exp_reg[0][1] = 8'hC3;
        ctrl_wr(1'b0, 8'h01); ctrl_rd(1'b0, r);
        chk("R2 reg1 after pointer write", r, 8'hC3);

        // R4: read data stable on every clock of the strobe
        ctrl_wr(1'b0, 8'h05);
        @(negedge clk);
        bus_rd = 1'b1; bus_chan_b = 1'b0; bus_data_sel = 1'b0; bus_as_n = 1'b0;
        for (int k = 0; k < HOLD; k++) begin
            @(negedge clk);
            chk("R4 stable read", bus_rdata, exp_reg[0][5]);
        end
        bus_as_n = 1'b1;
        repeat (GAP) @(negedge clk);
        chk("R4 rdata idle", bus_rdata, 8'h00);
        ctrl_rd(1'b0, r); chk("R3 after R4 read", r, 8'h00);

        // R10: data byte access keeps the index
        ctrl_wr(1'b0, 8'h07);
        bus(1'b0, 1'b0, 1'b1, 8'h5A, r);
        bus(1'b1, 1'b0, 1'b1, 8'h00, r);
        chk("R10 data readback", r, 8'h5A);
        bus(1'b1, 1'b1, 1'b1, 8'h00, r);
        chk("R10 data B untouched", r, 8'h00);
        ctrl_rd(1'b0, r);
        chk("R10 index kept", r, exp_reg[0][7]);

        // R7: clear acts on its own channel only
        pulse_evt(2'b11);
        ctrl_wr(1'b1, 8'h10);
        chk("R7 B cleared A kept", {6'b0, ext_pend}, 8'h01);
        ctrl_rd(1'b1, r); chk("R7 index stays 0", r, 8'h00);
        ctrl_wr(1'b0, 8'h10);
        chk("R7 A cleared", {6'b0, ext_pend}, 8'h00);

        // R8: event overlapping the clear command wins
        @(negedge clk); ext_evt = 2'b01;
        ctrl_wr(1'b0, 8'h10);
        chk("R8 set wins", {6'b0, ext_pend}, 8'h01);
        ext_evt = 2'b00;
        repeat (3) @(negedge clk);
        chk("R8 still set", {6'b0, ext_pend}, 8'h01);
        ctrl_wr(1'b0, 8'h10);
        chk("R8 later clear", {6'b0, ext_pend}, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule